// File: doc/BRIEF.md
# Transmit Length Guard

This block sits on the serial path between a bipolar Manchester encoder and the bus transmitter of a remote terminal. It watches the true and complement data lines on their way out and measures how long each outgoing message lasts. When a message runs past its allowed length, the block raises a latched fail-safe flag and holds both output lines low. The flag can also drive the inhibit input of the transmitter. The design runs from a 12 MHz clock, so the default limits are 9216 cycles (768 µs) for message length and 36 cycles (3 µs) for the longest gap that still counts as part of the same message.

The line pair is busy when either line is high. It is idle when both lines are low, and it is also treated as idle while the master reset input is held low. A short idle stretch does not end a message, so the length measurement runs straight through it. A pulse on master reset therefore cannot split one long transmission into two short ones. Once the flag is set it stays set after the message ends. Only a master reset, or a one-cycle pulse reporting a valid command word addressed to this terminal, clears it.

Top module: `tx_len_guard`

## Requirements
- R1: After the asynchronous power-up reset, `fail_safe` is 0 and both output lines equal the input lines.
- R2: While `fail_safe` is 0, `tx_out_pos` equals `tx_in_pos` and `tx_out_neg` equals `tx_in_neg` in the same cycle.
- R3: A cycle counts as busy when `mrst_n` is 1 and at least one input line is 1. A message that stays busy for 9216 consecutive cycles does not set the flag. A 9217th busy cycle sets `fail_safe` at the clock edge that ends that cycle.
- R4: While `fail_safe` is 1, both output lines are 0 whatever the input lines carry.
- R5: Once set, `fail_safe` stays 1 after the message ends, through any number of idle cycles, until a clear event occurs.
- R6: A cycle with `cmd_match` at 1 clears `fail_safe` at the end of that cycle. It takes priority over a trip in the same cycle.
- R7: A cycle with `mrst_n` at 0 clears `fail_safe` at the end of that cycle.
- R8: A run of up to 36 idle cycles inside a message does not end it, and those idle cycles add to the measured length. The 37th consecutive idle cycle ends the message and restarts the length measurement from zero.
- R9: Cycles with `mrst_n` at 0 count as idle for R8. A master reset pulse of up to 36 cycles inside a transmission therefore does not restart the length measurement.
- R10: The length measurement saturates at 9216 and does not wrap. If the flag is cleared while the same message is still busy, `fail_safe` is set again at the end of the next busy cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 12 MHz clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset, released synchronously |
| mrst_n | input | 1 | Active-low master reset; clears the flag and counts as line idle |
| cmd_match | input | 1 | One-cycle pulse: valid command word with this terminal's address received |
| tx_in_pos | input | 1 | True serial data line from the encoder |
| tx_in_neg | input | 1 | Complement serial data line from the encoder |
| tx_out_pos | output | 1 | Gated true data line toward the transmitter |
| tx_out_neg | output | 1 | Gated complement data line toward the transmitter |
| fail_safe | output | 1 | Registered, latched fail-safe flag; usable as transmitter inhibit |

## Verification
The assertions assume that `mrst_n` and `cmd_match` change only between clock edges and that `cmd_match` is a pulse rather than a level. The rule that the flag holds depends on neither clear input being active. The bench drives every input on the falling edge and samples outputs on the following falling edge, so each check sees the state after exactly one rising edge. The encoder lines are driven as an alternating complementary pattern, with both lines low between messages. The table of message shapes places each length and gap one cycle on either side of the 9216-cycle and 36-cycle limits.

// File: rtl/txg_pkg.sv
package txg_pkg;

  localparam int TRIP_CYCLES_DEF = 9216;
  localparam int GAP_CYCLES_DEF  = 36;

  typedef struct packed {
    logic pos;
    logic neg;
  } line_pair_t;

endpackage

// File: rtl/txg_activity.sv
module txg_activity
  import txg_pkg::*;
#(
  parameter int GAP_CYCLES = GAP_CYCLES_DEF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mrst_n,
  input  line_pair_t lines_i,
  output logic       busy_o,
  output logic       msg_end_o
);

  localparam int GW = $clog2(GAP_CYCLES + 2);
  localparam logic [GW-1:0] GAP_SAT = GW'(GAP_CYCLES + 1);

  logic [GW-1:0] idle_q;
  logic [GW-1:0] idle_d;
  logic          idle_en;

  // master reset low is seen as an idle line
  assign busy_o = (lines_i.pos | lines_i.neg) & mrst_n;

  always_comb begin
    if (busy_o) begin
      idle_d  = '0;
      idle_en = (idle_q != '0);
    end else begin
      idle_d  = (idle_q == GAP_SAT) ? idle_q : idle_q + GW'(1);
      idle_en = (idle_q != GAP_SAT);
    end
  end

  // this idle cycle is the first one beyond the allowed gap
  assign msg_end_o = ~busy_o & (idle_d == GAP_SAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
    end else if (idle_en) begin
      idle_q <= idle_d;
    end
  end

endmodule

// File: rtl/txg_length.sv
module txg_length
  import txg_pkg::*;
#(
  parameter int TRIP_CYCLES = TRIP_CYCLES_DEF,
  localparam int LW = $clog2(TRIP_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          msg_end_i,
  output logic          at_limit_o,
  output logic [LW-1:0] len_o
);

  localparam logic [LW-1:0] LEN_MAX = LW'(TRIP_CYCLES);

  logic [LW-1:0] len_q;
  logic [LW-1:0] len_d;
  logic [LW-1:0] len_inc;
  logic          len_en;

  assign len_inc = (len_q == LEN_MAX) ? len_q : len_q + LW'(1);

  always_comb begin
    if (msg_end_i) begin
      len_d = '0;
    end else if (busy_i) begin
      len_d = len_inc;
    end else if (len_q != '0) begin
      len_d = len_inc;            // short gap inside a message keeps counting
    end else begin
      len_d = '0;
    end
    len_en = (len_d != len_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_en) begin
      len_q <= len_d;
    end
  end

  assign at_limit_o = (len_q == LEN_MAX);
  assign len_o      = len_q;

endmodule

// File: rtl/txg_flag.sv
module txg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic clear_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    if (clear_i) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q | trip_i;
    end
    flag_en = (flag_d != flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/tx_len_guard.sv
module tx_len_guard
  import txg_pkg::*;
#(
  parameter int TRIP_CYCLES = TRIP_CYCLES_DEF,
  parameter int GAP_CYCLES  = GAP_CYCLES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mrst_n,
  input  logic cmd_match,
  input  logic tx_in_pos,
  input  logic tx_in_neg,
  output logic tx_out_pos,
  output logic tx_out_neg,
  output logic fail_safe
);

  localparam int LW = $clog2(TRIP_CYCLES + 1);

  line_pair_t    lines;
  logic          busy;
  logic          msg_end;
  logic          at_limit;
  logic [LW-1:0] len_q;
  logic          trip;
  logic          clear;
  logic          flag;

  assign lines.pos = tx_in_pos;
  assign lines.neg = tx_in_neg;

  txg_activity #(.GAP_CYCLES(GAP_CYCLES)) activity_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mrst_n    (mrst_n),
    .lines_i   (lines),
    .busy_o    (busy),
    .msg_end_o (msg_end)
  );

  txg_length #(.TRIP_CYCLES(TRIP_CYCLES)) length_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (busy),
    .msg_end_i  (msg_end),
    .at_limit_o (at_limit),
    .len_o      (len_q)
  );

  assign trip  = at_limit & busy;
  assign clear = ~mrst_n | cmd_match;

  txg_flag flag_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .trip_i  (trip),
    .clear_i (clear),
    .flag_o  (flag)
  );

  assign fail_safe  = flag;
  assign tx_out_pos = tx_in_pos & ~flag;
  assign tx_out_neg = tx_in_neg & ~flag;

endmodule

// File: rtl/tx_len_guard_chk.sv
module tx_len_guard_chk #(
  parameter int TRIP_CYCLES = 9216,
  parameter int LW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mrst_n,
  input logic          cmd_match,
  input logic          tx_in_pos,
  input logic          tx_in_neg,
  input logic          tx_out_pos,
  input logic          tx_out_neg,
  input logic          fail_safe,
  input logic [LW-1:0] len_q
);

  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_safe |-> (tx_out_pos == tx_in_pos) && (tx_out_neg == tx_in_neg)); // R2

  AST_OUT_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    fail_safe |-> !tx_out_pos && !tx_out_neg); // R4

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    fail_safe && mrst_n && !cmd_match |=> fail_safe); // R5

  AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_match |=> !fail_safe); // R6

  AST_MRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !mrst_n |=> !fail_safe); // R7

  AST_RISE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_safe) |-> $past(mrst_n && (tx_in_pos || tx_in_neg))); // R3

  AST_LEN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LW'(TRIP_CYCLES)); // R10

endmodule

bind tx_len_guard tx_len_guard_chk #(.TRIP_CYCLES(TRIP_CYCLES), .LW(LW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mrst_n     (mrst_n),
  .cmd_match  (cmd_match),
  .tx_in_pos  (tx_in_pos),
  .tx_in_neg  (tx_in_neg),
  .tx_out_pos (tx_out_pos),
  .tx_out_neg (tx_out_neg),
  .fail_safe  (fail_safe),
  .len_q      (len_q)
);

// File: tb/tx_len_guard_tb_top.sv
module tx_len_guard_tb_top;

  localparam int CLK_PERIOD = 84;
  localparam int TRIP = 9216;
  localparam int NVEC = 6;
  // {busy cycles, idle gap, busy cycles, expected flag}
  localparam int VEC [NVEC][4] = '{
    '{9216, 0,  0,    0},
    '{9217, 0,  0,    1},
    '{5000, 36, 4180, 0},
    '{5000, 36, 4181, 1},
    '{5000, 37, 4181, 0},
    '{100,  0,  0,    0}
  };

  logic clk = 1'b0;
  logic rst_n, mrst_n, cmd_match, in_p, in_n;
  logic out_p, out_n, fail_safe;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tx_len_guard dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mrst_n     (mrst_n),
    .cmd_match  (cmd_match),
    .tx_in_pos  (in_p),
    .tx_in_neg  (in_n),
    .tx_out_pos (out_p),
    .tx_out_neg (out_n),
    .fail_safe  (fail_safe)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_busy(input int n);
    for (int i = 0; i < n; i++) begin
      in_p = i[0];
      in_n = ~i[0];
      @(negedge clk);
    end
  endtask

  task automatic send_idle(input int n);
    in_p = 1'b0;
    in_n = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_mrst_and_settle();
    send_idle(40);
    mrst_n = 1'b0;
    @(negedge clk);
    mrst_n = 1'b1;
    send_idle(40);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++;
    bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mrst_n = 1'b1; cmd_match = 1'b0; in_p = 1'b0; in_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 flag under reset", fail_safe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag after reset", fail_safe, 0);
    in_p = 1'b1; in_n = 1'b0; #1;
    check("R1 pos passes", out_p, 1);
    check("R2 neg passes", out_n, 0);
    in_p = 1'b0; in_n = 1'b1; #1;
    check("R2 neg passes high", out_n, 1);
    send_idle(40);

    // table of message shapes: R3 and R8
    for (int v = 0; v < NVEC; v++) begin
      send_busy(VEC[v][0]);
      send_idle(VEC[v][1]);
      send_busy(VEC[v][2]);
      check("R3/R8 flag after message", fail_safe, VEC[v][3]);
      in_p = 1'b1; in_n = 1'b0; #1;
      check("R4/R2 gated pos line", out_p, VEC[v][3] ? 0 : 1);
      send_idle(40);
      check("R5 flag after idle", fail_safe, VEC[v][3]);
      pulse_mrst_and_settle();
      check("R7 flag after master reset", fail_safe, 0);
    end

    // exact trip edge, R3
    send_busy(TRIP);
    check("R3 no trip at limit", fail_safe, 0);
    send_busy(1);
    check("R3 trip one past limit", fail_safe, 1);
    in_p = 1'b1; in_n = 1'b1; #1;
    check("R4 pos muted", out_p, 0);
    check("R4 neg muted", out_n, 0);
    // clear while still busy, then retrip: R6 and R10
    cmd_match = 1'b1;
    @(negedge clk);
    cmd_match = 1'b0;
    check("R6 command clears while busy", fail_safe, 0);
    send_busy(1);
    check("R10 saturated length retrips", fail_safe, 1);
    // flag stays through idle, then command clears: R5 and R6
    send_idle(60);
    check("R5 flag held across long idle", fail_safe, 1);
    cmd_match = 1'b1;
    @(negedge clk);
    cmd_match = 1'b0;
    check("R6 command clears when idle", fail_safe, 0);
    send_busy(50);
    check("R6 short message after clear", fail_safe, 0);
    in_p = 1'b1; in_n = 1'b0; #1;
    check("R6 output passes after clear", out_p, 1);
    pulse_mrst_and_settle();

    // master reset gap inside a message: R9
    send_busy(9000);
    mrst_n = 1'b0;
    in_p = 1'b1; in_n = 1'b0;
    repeat (10) @(negedge clk);
    mrst_n = 1'b1;
    send_busy(300);
    check("R9 short reset gap keeps timing", fail_safe, 1);
    pulse_mrst_and_settle();
    send_busy(9000);
    mrst_n = 1'b0;
    in_p = 1'b1; in_n = 1'b0;
    repeat (40) @(negedge clk);
    mrst_n = 1'b1;
    send_busy(300);
    check("R9 long reset gap restarts timing", fail_safe, 0);
    send_idle(5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule